// File: doc/BRIEF.md
# Dual-Prime Barrett Modular Multiplier

This block is a pipelined modular multiplier for lattice cryptography arithmetic. It computes `a*b mod q`, and both operands must already be reduced modulo q. A mode input picks the modulus per transaction. With the mode input high the modulus is the 23-bit prime 8380417. With the mode input low it is the 12-bit prime 3329. The unit accepts one transaction per clock cycle and returns each result a fixed five cycles later, with a valid flag that travels alongside the data.

The reduction uses the Barrett method. The full product is multiplied by a per-prime reciprocal constant, and the high part of that result is an estimate of the quotient. This estimate is multiplied by q and subtracted from the product. At most two conditional subtractions of q then give the exact remainder. The multiplications by the reciprocal constant and by q are not general multipliers. Each is a small, fixed shift-and-add network for its prime.

In the 12-bit mode only the low half of each pipeline register carries live data. The upper halves are not loaded, so they hold their values and do not toggle.

Top module: `pqmul_top`

## Requirements
- R1: With `in_wide`=1, `out_res` equals `(in_a*in_b) mod 8380417` for all operands in [0, 8380416].
- R2: With `in_wide`=0, `out_res` equals `(in_a[11:0]*in_b[11:0]) mod 3329` for all low-field operands in [0, 3328].
- R3: With `in_wide`=0, operand bits 22..12 have no effect on the result.
- R4: `out_valid` is `in_valid` delayed by exactly 5 clock cycles in both modes. A new transaction may enter every cycle, and every accepted transaction produces exactly one result.
- R5: Every valid result is below the modulus of its own transaction.
- R6: While reset is asserted and after it is released, with no input yet, `out_valid` is 0 and `out_res` is 0.
- R7: In 12-bit mode the upper halves of the product, quotient and remainder registers keep their previous values. A later 23-bit transaction is not affected by whatever those halves hold.
- R8: `in_wide` may change only while no transaction is in flight. The first results after a mode change are exact.
- R9: Operands must lie in [0, q-1], meaning the low 12 bits in 12-bit mode. The extreme operands 0 and q-1 give exact results (for example, (q-1)*(q-1) gives 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Transaction strobe for the operands |
| in_wide | input | 1 | 1 selects modulus 8380417, 0 selects modulus 3329 |
| in_a | input | 23 | First operand, already reduced |
| in_b | input | 23 | Second operand, already reduced |
| out_valid | output | 1 | Result strobe, 5 cycles after `in_valid` |
| out_res | output | 23 | Reduced product |

## Verification
The bound checker holds a five-deep copy of the inputs. On every cycle it compares each result with an independently computed modulo, and it checks the valid timing, the output bound and the operand and mode-change rules. It also watches the upper register halves, which must stay stable while a 12-bit transaction passes through each stage.

The bench scenarios cover what only sequences can show:
- the reset state;
- directed extreme operands;
- long back-to-back random streams and streams with bubbles;
- junk in the unused upper operand bits;
- mode switches in both directions after the pipeline drains.

The switches show that stale upper-half contents never leak into a 23-bit result.

// File: rtl/pqmul_pkg.sv
package pqmul_pkg;

  // operand and narrow-field widths
  localparam int unsigned OPW     = 23;
  localparam int unsigned NW      = 12;
  localparam int unsigned LAT     = 5;

  // derived widths
  localparam int unsigned PROD_W  = 2 * OPW;       // full product
  localparam int unsigned NPROD_W = 2 * NW;        // narrow product
  localparam int unsigned NQW     = NW + 1;        // narrow quotient estimate
  localparam int unsigned RW      = OPW + 2;       // partial remainder, < 3q
  localparam int unsigned NRW     = NW + 2;
  localparam int unsigned TW      = PROD_W + OPW;  // x*m, wide
  localparam int unsigned NTW     = NPROD_W + NQW; // x*m, narrow

  localparam logic [OPW-1:0] Q_WIDE   = 23'd8380417; // 2^23 - 2^13 + 1
  localparam logic [NW-1:0]  Q_NARROW = 12'd3329;    // 2^11 + 2^10 + 2^8 + 1

  // floor(x * 8396807 / 2^46); 8396807 = 2^23 + 2^13 + 2^3 - 1
  function automatic logic [OPW-1:0] quot_wide(input logic [PROD_W-1:0] x);
    logic [TW-1:0] e;
    logic [TW-1:0] t;
    e = TW'(x);
    t = (e << 23) + (e << 13) + (e << 3) - e;
    return OPW'(t >> PROD_W);
  endfunction

  // floor(x * 5039 / 2^24); 5039 = 2^12 + 2^10 - 2^6 - 2^4 - 1
  function automatic logic [NQW-1:0] quot_narrow(input logic [NPROD_W-1:0] x);
    logic [NTW-1:0] e;
    logic [NTW-1:0] t;
    e = NTW'(x);
    t = (e << 12) + (e << 10) - (e << 6) - (e << 4) - e;
    return NQW'(t >> NPROD_W);
  endfunction

  // qh * 8380417 modulo 2^RW
  function automatic logic [RW-1:0] qmul_wide(input logic [OPW-1:0] qh);
    logic [RW-1:0] e;
    e = RW'(qh);
    return (e << 23) - (e << 13) + e;
  endfunction

  // qh * 3329 modulo 2^NRW
  function automatic logic [NRW-1:0] qmul_narrow(input logic [NQW-1:0] qh);
    logic [NRW-1:0] e;
    e = NRW'(qh);
    return (e << 11) + (e << 10) + (e << 8) + e;
  endfunction

endpackage

// File: rtl/pqmul_splitreg.sv
// Register split into a low half loaded on every enable and an upper half
// loaded only for wide-mode transactions.
module pqmul_splitreg #(
  parameter int unsigned LO_W = 12,
  parameter int unsigned HI_W = 11
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic                   wide,
  input  logic [LO_W+HI_W-1:0]   d,
  output logic [LO_W+HI_W-1:0]   q
);
  logic [LO_W-1:0] lo_q, lo_n;

  always_comb lo_n = en ? d[LO_W-1:0] : lo_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lo_q <= '0;
    else        lo_q <= lo_n;

  generate
    if (HI_W > 0) begin : g_hi
      logic [HI_W-1:0] hi_q;
      logic            hi_en;
      assign hi_en = en & wide;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)     hi_q <= '0;
        else if (hi_en) hi_q <= d[LO_W+HI_W-1:LO_W];
      assign q = {hi_q, lo_q};
    end else begin : g_lo_only
      assign q = lo_q;
    end
  endgenerate
endmodule

// File: rtl/pqmul_product.sv
// Stage 1: operand capture. Stage 2: full or narrow product.
module pqmul_product
  import pqmul_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_wide,
  input  logic [OPW-1:0]    in_a,
  input  logic [OPW-1:0]    in_b,
  output logic              v1,
  output logic              w1,
  output logic              v2,
  output logic              w2,
  output logic [PROD_W-1:0] x
);
  logic [OPW-1:0]     a1, b1;
  logic               w1_n, w2_n;
  logic [PROD_W-1:0]  prod_n;
  logic [NPROD_W-1:0] prod_narrow;

  pqmul_splitreg #(.LO_W(NW), .HI_W(OPW-NW)) u_opa (
    .clk(clk), .rst_n(rst_n), .en(in_valid), .wide(in_wide), .d(in_a), .q(a1));
  pqmul_splitreg #(.LO_W(NW), .HI_W(OPW-NW)) u_opb (
    .clk(clk), .rst_n(rst_n), .en(in_valid), .wide(in_wide), .d(in_b), .q(b1));

  always_comb begin
    w1_n        = in_valid ? in_wide : w1;
    w2_n        = v1 ? w1 : w2;
    prod_narrow = {{NW{1'b0}}, a1[NW-1:0]} * {{NW{1'b0}}, b1[NW-1:0]};
    if (w1)
      prod_n = {{(PROD_W-OPW){1'b0}}, a1} * {{(PROD_W-OPW){1'b0}}, b1};
    else
      prod_n = {{(PROD_W-NPROD_W){1'b0}}, prod_narrow};
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      v1 <= 1'b0; w1 <= 1'b0; v2 <= 1'b0; w2 <= 1'b0;
    end else begin
      v1 <= in_valid; w1 <= w1_n; v2 <= v1; w2 <= w2_n;
    end

  pqmul_splitreg #(.LO_W(NPROD_W), .HI_W(PROD_W-NPROD_W)) u_prod (
    .clk(clk), .rst_n(rst_n), .en(v1), .wide(w1), .d(prod_n), .q(x));
endmodule

// File: rtl/pqmul_quot.sv
// Stage 3: Barrett quotient estimate via shift-add, plus low product bits.
module pqmul_quot
  import pqmul_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              v2,
  input  logic              w2,
  input  logic [PROD_W-1:0] x,
  output logic              v3,
  output logic              w3,
  output logic [OPW-1:0]    qh,
  output logic [RW-1:0]     rs
);
  logic           w3_n;
  logic [OPW-1:0] qh_n;
  logic [RW-1:0]  rs_n;

  always_comb begin
    w3_n = v2 ? w2 : w3;
    if (w2) begin
      qh_n = quot_wide(x);
      rs_n = x[RW-1:0];
    end else begin
      qh_n = {{(OPW-NQW){1'b0}}, quot_narrow(x[NPROD_W-1:0])};
      rs_n = {{(RW-NRW){1'b0}}, x[NRW-1:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      v3 <= 1'b0; w3 <= 1'b0;
    end else begin
      v3 <= v2; w3 <= w3_n;
    end

  pqmul_splitreg #(.LO_W(NQW), .HI_W(OPW-NQW)) u_qh (
    .clk(clk), .rst_n(rst_n), .en(v2), .wide(w2), .d(qh_n), .q(qh));
  pqmul_splitreg #(.LO_W(NRW), .HI_W(RW-NRW)) u_rs (
    .clk(clk), .rst_n(rst_n), .en(v2), .wide(w2), .d(rs_n), .q(rs));
endmodule

// File: rtl/pqmul_rem.sv
// Stage 4: partial remainder x - qh*q. Stage 5: two conditional subtractions.
module pqmul_rem
  import pqmul_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           v3,
  input  logic           w3,
  input  logic [OPW-1:0] qh,
  input  logic [RW-1:0]  rs,
  output logic           v4,
  output logic           w4,
  output logic [RW-1:0]  r,
  output logic           v5,
  output logic           w5,
  output logic [OPW-1:0] res
);
  logic           w4_n, w5_n;
  logic [RW-1:0]  r_n;
  logic [NRW-1:0] r_narrow;
  logic [RW-1:0]  rr, qsel, r1, r2;
  logic [OPW-1:0] res_n;

  always_comb begin
    w4_n     = v3 ? w3 : w4;
    r_narrow = rs[NRW-1:0] - qmul_narrow(qh[NQW-1:0]);
    if (w3) r_n = rs - qmul_wide(qh);
    else    r_n = {{(RW-NRW){1'b0}}, r_narrow};
  end

  pqmul_splitreg #(.LO_W(NRW), .HI_W(RW-NRW)) u_r (
    .clk(clk), .rst_n(rst_n), .en(v3), .wide(w3), .d(r_n), .q(r));

  always_comb begin
    w5_n  = v4 ? w4 : w5;
    rr    = w4 ? r : {{(RW-NRW){1'b0}}, r[NRW-1:0]};
    qsel  = w4 ? RW'(Q_WIDE) : RW'(Q_NARROW);
    r1    = (rr >= qsel) ? rr - qsel : rr;
    r2    = (r1 >= qsel) ? r1 - qsel : r1;
    res_n = v4 ? OPW'(r2) : res;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      v4 <= 1'b0; w4 <= 1'b0; v5 <= 1'b0; w5 <= 1'b0; res <= '0;
    end else begin
      v4 <= v3; w4 <= w4_n; v5 <= v4; w5 <= w5_n; res <= res_n;
    end
endmodule

// File: rtl/pqmul_top.sv
module pqmul_top
  import pqmul_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic           in_wide,
  input  logic [22:0]    in_a,
  input  logic [22:0]    in_b,
  output logic           out_valid,
  output logic [22:0]    out_res
);
  logic              v1, w1, v2, w2, v3, w3, v4, w4, w5;
  logic [PROD_W-1:0] x_q;
  logic [OPW-1:0]    qh_q;
  logic [RW-1:0]     rs_q, r_q;

  pqmul_product u_product (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_wide(in_wide),
    .in_a(in_a), .in_b(in_b), .v1(v1), .w1(w1), .v2(v2), .w2(w2), .x(x_q));

  pqmul_quot u_quot (
    .clk(clk), .rst_n(rst_n), .v2(v2), .w2(w2), .x(x_q),
    .v3(v3), .w3(w3), .qh(qh_q), .rs(rs_q));

  pqmul_rem u_rem (
    .clk(clk), .rst_n(rst_n), .v3(v3), .w3(w3), .qh(qh_q), .rs(rs_q),
    .v4(v4), .w4(w4), .r(r_q), .v5(out_valid), .w5(w5), .res(out_res));
endmodule

// File: rtl/pqmul_check.sv
module pqmul_check
  import pqmul_pkg::*;
(
  input logic                      clk,
  input logic                      rst_n,
  input logic                      in_valid,
  input logic                      in_wide,
  input logic [OPW-1:0]            in_a,
  input logic [OPW-1:0]            in_b,
  input logic                      out_valid,
  input logic [OPW-1:0]            out_res,
  input logic                      v1, w1, v2, w2, v3, w3, v4, w4, w5,
  input logic [PROD_W-NPROD_W-1:0] x_hi,
  input logic [OPW-NQW-1:0]        qh_hi,
  input logic [RW-NRW-1:0]         r_hi
);
  logic [OPW-1:0] ad [LAT];
  logic [OPW-1:0] bd [LAT];
  logic           vd [LAT];
  logic           wd [LAT];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < LAT; i++) begin
        ad[i] <= '0; bd[i] <= '0; vd[i] <= 1'b0; wd[i] <= 1'b0;
      end
    end else begin
      ad[0] <= in_a; bd[0] <= in_b; vd[0] <= in_valid; wd[0] <= in_wide;
      for (int i = 1; i < LAT; i++) begin
        ad[i] <= ad[i-1]; bd[i] <= bd[i-1]; vd[i] <= vd[i-1]; wd[i] <= wd[i-1];
      end
    end

  function automatic logic [OPW-1:0] model(input logic w, input logic [OPW-1:0] a,
                                           input logic [OPW-1:0] b);
    logic [63:0] aa, bb;
    aa = w ? 64'(a) : 64'(a[NW-1:0]);
    bb = w ? 64'(b) : 64'(b[NW-1:0]);
    return OPW'((aa * bb) % (w ? 64'(Q_WIDE) : 64'(Q_NARROW)));
  endfunction

  a_r4_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == vd[LAT-1]);
  a_r1_wide_exact: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && wd[LAT-1]) |-> out_res == model(1'b1, ad[LAT-1], bd[LAT-1]));
  a_r2_narrow_exact: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !wd[LAT-1]) |-> out_res == model(1'b0, ad[LAT-1], bd[LAT-1]));
  a_r5_below_q: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (w5 ? (out_res < Q_WIDE) : (out_res < OPW'(Q_NARROW))));
  a_r7_hold_product: assert property (@(posedge clk) disable iff (!rst_n)
    (v1 && !w1) |=> $stable(x_hi));
  a_r7_hold_quotient: assert property (@(posedge clk) disable iff (!rst_n)
    (v2 && !w2) |=> $stable(qh_hi));
  a_r7_hold_remainder: assert property (@(posedge clk) disable iff (!rst_n)
    (v3 && !w3) |=> $stable(r_hi));
  a_r8_mode_steady: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ((!v1 || w1 == in_wide) && (!v2 || w2 == in_wide) &&
                  (!v3 || w3 == in_wide) && (!v4 || w4 == in_wide) &&
                  (!out_valid || w5 == in_wide)));
  a_r9_wide_range: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_wide) |-> (in_a < Q_WIDE && in_b < Q_WIDE));
  a_r9_narrow_range: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_wide) |-> (in_a[NW-1:0] < Q_NARROW && in_b[NW-1:0] < Q_NARROW));
endmodule

bind pqmul_top pqmul_check u_check (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_wide(in_wide),
  .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_res(out_res),
  .v1(v1), .w1(w1), .v2(v2), .w2(w2), .v3(v3), .w3(w3), .v4(v4), .w4(w4), .w5(w5),
  .x_hi(x_q[pqmul_pkg::PROD_W-1:pqmul_pkg::NPROD_W]),
  .qh_hi(qh_q[pqmul_pkg::OPW-1:pqmul_pkg::NQW]),
  .r_hi(r_q[pqmul_pkg::RW-1:pqmul_pkg::NRW]));

// File: tb/pqmul_top_test.sv
module pqmul_top_test;
  import pqmul_pkg::*;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           in_valid = 1'b0;
  logic           in_wide = 1'b0;
  logic [OPW-1:0] in_a = '0;
  logic [OPW-1:0] in_b = '0;
  logic           out_valid;
  logic [OPW-1:0] out_res;

  pqmul_top uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_wide(in_wide),
                 .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_res(out_res));

  always #10 clk = ~clk;

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int unsigned n_chk = 0, n_fail = 0, seed = 32'h1d2c_3b4a;
  bit          done = 1'b0;

  logic [OPW-1:0] exp_q[$];
  logic           mode_q[$];
  int unsigned    cyc_q[$];
  string          tag_q[$];

  localparam int unsigned QW_I = 8380417;
  localparam int unsigned QN_I = 3329;

  function automatic logic [OPW-1:0] ref_mod(input logic w, input logic [OPW-1:0] a,
                                             input logic [OPW-1:0] b);
    logic [63:0] aa, bb;
    aa = w ? 64'(a) : 64'(a[11:0]);
    bb = w ? 64'(b) : 64'(b[11:0]);
    return OPW'((aa * bb) % (w ? 64'(QW_I) : 64'(QN_I)));
  endfunction

  function automatic int unsigned rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  task automatic check(input bit ok, input string tag, input longint unsigned act,
                       input longint unsigned expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic send(input logic w, input logic [OPW-1:0] a, input logic [OPW-1:0] b,
                      input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_wide = w; in_a = a; in_b = b;
    exp_q.push_back(ref_mod(w, a, b));
    mode_q.push_back(w);
    cyc_q.push_back(cyc);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R4 result without transaction", 1, 0);
      end else begin
        logic [OPW-1:0] e;
        logic           m;
        int unsigned    c;
        string          t;
        e = exp_q.pop_front(); m = mode_q.pop_front();
        c = cyc_q.pop_front(); t = tag_q.pop_front();
        check(out_res == e, t, out_res, e);
        check(cyc - c == LAT, "R4 latency", cyc - c, LAT);
        check(out_res < (m ? QW_I : QN_I), "R5 result below modulus", out_res,
              m ? QW_I : QN_I);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R6 valid low in reset", out_valid, 0);
    rst_n = 1'b1;
    idle(2);
    check(out_valid == 1'b0, "R6 valid low after reset", out_valid, 0);
    check(out_res == '0, "R6 result zero after reset", out_res, 0);

    // wide mode, extremes then random back-to-back
    send(1'b1, 23'd0, 23'd0, "R9 wide zero operands");
    send(1'b1, 23'(QW_I-1), 23'(QW_I-1), "R9 wide (q-1)^2");
    send(1'b1, 23'(QW_I-1), 23'd1, "R9 wide (q-1)*1");
    send(1'b1, 23'(QW_I-1), 23'd2, "R1 wide (q-1)*2");
    send(1'b1, 23'd4194304, 23'd4194304, "R1 wide 2^22 squared");
    send(1'b1, 23'd8380416, 23'd4190208, "R1 wide near half");
    for (int i = 0; i < 40; i++)
      send(1'b1, 23'(rnd() % QW_I), 23'(rnd() % QW_I), "R1 wide random");
    idle(LAT + 2);

    // narrow mode after drain
    send(1'b0, 23'd3328, 23'd3328, "R8 first narrow after switch");
    send(1'b0, 23'd0, 23'd3328, "R9 narrow zero operand");
    send(1'b0, 23'd3328, 23'd1, "R9 narrow (q-1)*1");
    for (int i = 0; i < 40; i++)
      send(1'b0, 23'(rnd() % QN_I), 23'(rnd() % QN_I), "R2 narrow random");
    for (int i = 0; i < 8; i++)
      send(1'b0, {11'(rnd()), 12'(rnd() % QN_I)}, {11'h7ff, 12'(rnd() % QN_I)},
           "R3 narrow upper bits ignored");
    for (int i = 0; i < 6; i++) begin
      send(1'b0, 23'(rnd() % QN_I), 23'(rnd() % QN_I), "R4 narrow with bubbles");
      idle(1 + (i % 3));
    end
    idle(LAT + 2);

    // back to wide after narrow traffic
    send(1'b1, 23'(QW_I-1), 23'(QW_I-1), "R7 wide after narrow (q-1)^2");
    for (int i = 0; i < 12; i++)
      send(1'b1, 23'(rnd() % QW_I), 23'(rnd() % QW_I), "R7 wide after narrow random");
    for (int i = 0; i < 4; i++) begin
      send(1'b1, 23'(rnd() % QW_I), 23'(rnd() % QW_I), "R4 wide with bubbles");
      idle(2);
    end
    idle(LAT + 4);
    check(exp_q.size() == 0, "R4 every transaction answered", exp_q.size(), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule